// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short last-in, first-out record of how transmitted frames ended. The transmit engine reports each finished frame with one strobe and a few flags. The flags are the host's success-indication request, which the engine copies from bit 15 of the frame's descriptor word, plus jabber, underrun and collision-limit results. The block turns a report into an 8-bit status entry only when the frame ended in an error or the host asked to be told of success. Clean frames that carry no request leave no trace.

The host always sees the newest entry on a status port. It removes that entry by issuing a write strobe. An interrupt request stays raised while any entry is held. If a report arrives when every slot is taken, the block does not store it. It marks the overflow inside the newest entry instead. A jabber or underrun result stops the transmitter: a disable output is raised and all further frame reports are ignored. This lasts until a transmit reset empties the stack and clears the disable.

Top module: `tx_cstat_stack`

## Requirements
- R1: After reset, status_o is 8'h00, level_o is 0, irq_o is 0 and tx_disabled_o is 0.
- R2: A frame report creates an entry only if at least one of frm_req_i, frm_jabber_i, frm_underrun_i or frm_maxcoll_i is set. Otherwise level_o and status_o do not change.
- R3: An entry byte holds these bits: bit 7 = 1 (complete), bit 6 = request, bit 5 = jabber, bit 4 = underrun, bit 3 = collision limit, bit 2 = 0 when stored, bits 1..0 = 0.
- R4: status_o shows the most recently stored entry, or 8'h00 when the stack is empty. A host_pop_i removes that entry and exposes the one stored before it. A pop on an empty stack has no effect.
- R5: A report that would create an entry while level_o equals DEPTH stores nothing new. It sets bit 2 of the newest entry, and level_o stays at DEPTH.
- R6: A pop and an entry-creating report in the same cycle replace the newest entry with the new one. level_o does not change and no overflow is flagged. On an empty stack, the report is simply stored.
- R7: irq_o is 1 exactly when level_o is nonzero.
- R8: A stored or attempted entry with jabber or underrun set raises tx_disabled_o. While it is high, frame reports are ignored, and pops still work.
- R9: tx_reset_i empties the stack and clears tx_disabled_o. It takes precedence over a pop or report in the same cycle.
- R10: All outputs change on the clock edge that samples the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done_i | input | 1 | One-cycle strobe: a frame has finished |
| frm_req_i | input | 1 | Success indication requested (descriptor bit 15) |
| frm_jabber_i | input | 1 | Frame ended in a jabber error |
| frm_underrun_i | input | 1 | Frame ended in a FIFO underrun |
| frm_maxcoll_i | input | 1 | Frame hit the collision limit |
| host_pop_i | input | 1 | Host write strobe that removes the newest entry |
| tx_reset_i | input | 1 | Transmit reset: clear stack and disable |
| status_o | output | 8 | Newest entry, 8'h00 when empty |
| level_o | output | $clog2(DEPTH+1) | Number of entries held |
| irq_o | output | 1 | Completion interrupt request |
| tx_disabled_o | output | 1 | Transmitter stopped by a fatal error |

## Verification
Every output is a register, so each result is due right after the rising edge that samples its stimulus. There is exactly one edge of latency for stores, pops, overflow marking, the interrupt and the disable. The bench changes inputs on the falling edge and compares all four outputs at the following falling edge. It uses a reference stack that applies the requirements' rules for that one edge. Because of this, a late or early update shows up as a mismatch on that very cycle.

// File: rtl/tx_cstat_pkg.sv
package tx_cstat_pkg;
  localparam int BIT_DONE = 7;
  localparam int BIT_REQ  = 6;
  localparam int BIT_JAB  = 5;
  localparam int BIT_UND  = 4;
  localparam int BIT_MAXC = 3;
  localparam int BIT_OVF  = 2;
  localparam int ENTRY_W  = 8;

  typedef logic [ENTRY_W-1:0] entry_t;

  typedef struct packed {
    logic req;
    logic jabber;
    logic underrun;
    logic maxcoll;
  } frm_evt_t;

  function automatic entry_t make_entry(frm_evt_t e);
    entry_t r;
    r = '0;
    r[BIT_DONE] = 1'b1;
    r[BIT_REQ]  = e.req;
    r[BIT_JAB]  = e.jabber;
    r[BIT_UND]  = e.underrun;
    r[BIT_MAXC] = e.maxcoll;
    return r;
  endfunction
endpackage

// File: rtl/tx_cstat_encode.sv
module tx_cstat_encode
  import tx_cstat_pkg::*;
(
  input  logic     done_i,
  input  frm_evt_t evt_i,
  input  logic     disabled_i,
  output logic     push_o,
  output logic     fatal_o,
  output entry_t   entry_o
);
  logic noteworthy;

  always_comb begin
    noteworthy = evt_i.req | evt_i.jabber | evt_i.underrun | evt_i.maxcoll;
    push_o     = done_i & ~disabled_i & noteworthy;
    fatal_o    = push_o & (evt_i.jabber | evt_i.underrun);
    entry_o    = make_entry(evt_i);
  end

  // R3
  always_comb begin
    if (push_o) begin
      entry_bits_chk: assert (entry_o[1:0] == 2'b00 && entry_o[BIT_OVF] == 1'b0 && entry_o[BIT_DONE]);
    end
  end
endmodule

// File: rtl/tx_cstat_lifo.sv
module tx_cstat_lifo
  import tx_cstat_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             push_i,
  input  entry_t           entry_i,
  input  logic             pop_i,
  output entry_t           top_o,
  output logic [LVL_W-1:0] cnt_o,
  output logic [LVL_W-1:0] cnt_next_o
);
  entry_t             mem [DEPTH];
  entry_t             top_q, top_n, wr_data;
  logic [LVL_W-1:0]   cnt_q, cnt_n;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic               wr_en, do_pop, full;

  always_comb begin
    do_pop  = pop_i && (cnt_q != '0);
    full    = (cnt_q == LVL_W'(DEPTH));
    rd_idx  = IDX_W'(cnt_q - LVL_W'(2));
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = entry_i;
    cnt_n   = cnt_q;
    top_n   = top_q;
    if (clr_i) begin
      cnt_n = '0;
      top_n = '0;
    end else if (do_pop && push_i) begin
      wr_en  = 1'b1;
      wr_idx = IDX_W'(cnt_q - LVL_W'(1));
      top_n  = entry_i;
    end else if (do_pop) begin
      cnt_n = cnt_q - LVL_W'(1);
      top_n = (cnt_q > LVL_W'(1)) ? mem[rd_idx] : '0;
    end else if (push_i && !full) begin
      wr_en  = 1'b1;
      wr_idx = IDX_W'(cnt_q);
      cnt_n  = cnt_q + LVL_W'(1);
      top_n  = entry_i;
    end else if (push_i) begin
      wr_en   = 1'b1;
      wr_idx  = IDX_W'(DEPTH - 1);
      wr_data = top_q | (entry_t'(1) << BIT_OVF);
      top_n   = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      top_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      top_q <= top_n;
    end
  end

  assign top_o      = top_q;
  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_n;

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= LVL_W'(DEPTH));
  // R5
  ovf_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && full && !pop_i && !clr_i) |=> (top_q[BIT_OVF] && cnt_q == LVL_W'(DEPTH)));
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !clr_i && cnt_q == '0) |=> (cnt_q == '0 && top_q == '0));
  // R6
  swap_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && push_i && !clr_i && cnt_q != '0) |=> $stable(cnt_q));
  // R2
  stored_done_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !clr_i) |=> top_q[BIT_DONE]);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0 && top_q == '0));
endmodule

// File: rtl/tx_cstat_ctrl.sv
module tx_cstat_ctrl #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             fatal_i,
  input  logic [LVL_W-1:0] cnt_next_i,
  input  logic [LVL_W-1:0] cnt_i,
  output logic             irq_o,
  output logic             disabled_o
);
  logic irq_q, dis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      irq_q <= (cnt_next_i != '0);
      if (clr_i)        dis_q <= 1'b0;
      else if (fatal_i) dis_q <= 1'b1;
    end
  end

  assign irq_o      = irq_q;
  assign disabled_o = dis_q;

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (rst) irq_q == (cnt_i != '0));
  // R8
  dis_hold_chk: assert property (@(posedge clk) disable iff (rst) (dis_q && !clr_i) |=> dis_q);
  // R9
  dis_clear_chk: assert property (@(posedge clk) disable iff (rst) clr_i |=> !dis_q);
endmodule

// File: rtl/tx_cstat_stack.sv
module tx_cstat_stack
  import tx_cstat_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_done_i,
  input  logic             frm_req_i,
  input  logic             frm_jabber_i,
  input  logic             frm_underrun_i,
  input  logic             frm_maxcoll_i,
  input  logic             host_pop_i,
  input  logic             tx_reset_i,
  output logic [7:0]       status_o,
  output logic [LVL_W-1:0] level_o,
  output logic             irq_o,
  output logic             tx_disabled_o
);
  frm_evt_t         evt;
  logic             push, fatal, disabled;
  entry_t           entry, top;
  logic [LVL_W-1:0] cnt, cnt_next;

  assign evt = '{req: frm_req_i, jabber: frm_jabber_i,
                 underrun: frm_underrun_i, maxcoll: frm_maxcoll_i};

  tx_cstat_encode u_enc (
    .done_i     (frm_done_i),
    .evt_i      (evt),
    .disabled_i (disabled),
    .push_o     (push),
    .fatal_o    (fatal),
    .entry_o    (entry)
  );

  tx_cstat_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (tx_reset_i),
    .push_i     (push),
    .entry_i    (entry),
    .pop_i      (host_pop_i),
    .top_o      (top),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  tx_cstat_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (tx_reset_i),
    .fatal_i    (fatal),
    .cnt_next_i (cnt_next),
    .cnt_i      (cnt),
    .irq_o      (irq_o),
    .disabled_o (disabled)
  );

  assign status_o      = top;
  assign level_o       = cnt;
  assign tx_disabled_o = disabled;

  // R8
  ignore_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (disabled && frm_done_i && !host_pop_i && !tx_reset_i) |=> $stable(level_o));
endmodule

// File: tb/tx_cstat_stack_bench.sv
module tx_cstat_stack_bench;
  localparam int DEPTH = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic done = 0, req = 0, jab = 0, und = 0, mc = 0, pop = 0, trst = 0;
  logic [7:0] status;
  logic [LVL_W-1:0] level;
  logic irq, dis;

  always #2.5 clk = ~clk;

  tx_cstat_stack #(.DEPTH(DEPTH)) u_tx_cstat_stack (
    .clk(clk), .rst(rst), .frm_done_i(done), .frm_req_i(req),
    .frm_jabber_i(jab), .frm_underrun_i(und), .frm_maxcoll_i(mc),
    .host_pop_i(pop), .tx_reset_i(trst), .status_o(status),
    .level_o(level), .irq_o(irq), .tx_disabled_o(dis)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] m [DEPTH];
  int mcnt = 0;
  bit mdis = 0;

  function automatic logic [7:0] enc(bit r, bit j, bit u, bit c);
    return {1'b1, r, j, u, c, 3'b000};
  endfunction

  function automatic logic [7:0] mtop();
    return (mcnt == 0) ? 8'h00 : m[mcnt-1];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit d, bit r, bit j, bit u, bit c, bit p, bit t);
    bit psh;
    if (t) begin mcnt = 0; mdis = 0; return; end
    psh = d && !mdis && (r | j | u | c);
    if (p && mcnt > 0 && psh)      m[mcnt-1] = enc(r, j, u, c);
    else if (p && mcnt > 0)        mcnt--;
    else if (psh && mcnt < DEPTH)  begin m[mcnt] = enc(r, j, u, c); mcnt++; end
    else if (psh)                  m[DEPTH-1] = m[DEPTH-1] | 8'h04;
    if (psh && (j | u)) mdis = 1;
  endtask

  // R10: drive at falling edge, compare at the next falling edge
  task automatic step(string tag, bit d, bit r, bit j, bit u, bit c, bit p, bit t);
    done = d; req = r; jab = j; und = u; mc = c; pop = p; trst = t;
    model(d, r, j, u, c, p, t);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "status", status, mtop());
    chk(tag, "level", level, mcnt);
    chk(tag, "irq", irq, mcnt != 0);
    chk(tag, "disabled", dis, mdis);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int s;
    s = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1", "status", status, 0); chk("R1", "level", level, 0);
    chk("R1", "irq", irq, 0);       chk("R1", "disabled", dis, 0);
    // R2: clean frame, no request
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    chk("R2", "level clean", level, 0);
    // R3: request-only and collision-limit encodings
    step("R3", 1, 1, 0, 0, 0, 0, 0);
    chk("R3", "req entry", status, 8'hC0);
    step("R3", 1, 0, 0, 0, 1, 0, 0);
    chk("R3", "maxcoll entry", status, 8'h88);
    // R7
    chk("R7", "irq with entries", irq, 1);
    // R4: pop order and pop on empty
    step("R4", 0, 0, 0, 0, 0, 1, 0);
    chk("R4", "after pop", status, 8'hC0);
    step("R4", 0, 0, 0, 0, 0, 1, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 0);
    chk("R4", "empty pop", level, 0);
    chk("R7", "irq empty", irq, 0);
    // R6: pop+push on empty stores
    step("R6", 1, 1, 0, 0, 1, 1, 0);
    chk("R6", "empty swap", level, 1);
    // R5: fill and overflow
    for (int i = 0; i < DEPTH - 1; i++) step("R5", 1, 1, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 0, 0, 1, 0, 0);
    chk("R5", "full level", level, DEPTH);
    chk("R5", "ovf bit", status, 8'hC4);
    // R6: swap at full, no overflow
    step("R6", 1, 0, 0, 0, 1, 1, 0);
    chk("R6", "swap top", status, 8'h88);
    chk("R6", "swap level", level, DEPTH);
    step("R4", 0, 0, 0, 0, 0, 1, 0);
    chk("R4", "below top", status, 8'hC0);
    // R8: underrun disables, later reports ignored, pop works
    step("R8", 1, 0, 0, 1, 0, 0, 0);
    chk("R8", "disabled", dis, 1);
    step("R8", 1, 1, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 0);
    chk("R8", "pop while off", status, 8'hC0);
    // R9: reset wins over same-cycle push and pop
    step("R9", 1, 0, 1, 0, 0, 1, 1);
    chk("R9", "cleared", level, 0);
    chk("R9", "re-enabled", dis, 0);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      bit d, r, j, u, c, p, t;
      d = ($urandom % 2) == 0;
      r = ($urandom % 3) == 0;
      j = ($urandom % 24) == 0;
      u = ($urandom % 24) == 0;
      c = ($urandom % 5) == 0;
      p = ($urandom % 3) == 0;
      t = ($urandom % 40) == 0;
      step("R4", d, r, j, u, c, p, t);
    end
    summary();
  end
endmodule